// File: doc/BRIEF.md
# Two-way set-associative instruction cache

This block sits between a processor core's instruction fetch path and a slow external code memory. The core presents byte addresses from a 24-bit space and waits for a ready pulse. The cache keeps recently fetched code in a two-way set-associative store, by default 512 sets of two 16-byte lines. A fetch that hits is answered from the store with no external access. A fetch that misses brings in the whole line, four 32-bit words, over a simple request/acknowledge memory port. The core is released as soon as its own word arrives, and the rest of the line keeps filling.

Only fetches that fall in the external code window are cached. The window starts at byte 0x028000. When the on-chip ROM is mapped (`rom_en` high), the window ends below 0x FF8000. Otherwise it runs to the top of the space. Three controls shape the behaviour. `cache_en` turns caching on. `freeze` keeps serving hits but stops all allocation and LRU updates. `flush` invalidates every line in a single cycle. A status bit returned with each word tells whether that word came from the cache.

Top module: `icache2w`

## Requirements
- R1: A fetch whose line is present and valid returns the word at its address with `fetch_hit`=1 and makes no memory request. The address splits into byte offset [3:0], word select [3:2], set index [IDX_W+3:4] and tag above that.
- R2: A cacheable miss with the cache enabled and not frozen reads four words in ascending order, starting at the line-aligned address. `fetch_ready` pulses when the word selected by [3:2] arrives, with that word on `fetch_data` and `fetch_hit`=0.
- R3: Each way keeps its own tag, so two lines with the same set index and different tags are both resident after filling and both hit.
- R4: A miss fills an invalid way first, way 0 before way 1. If both ways are valid, it replaces the least recently used way. A hit or a fill makes the other way of that set the least recently used.
- R5: An address is cacheable when it is at least 0x028000 and, with `rom_en`=1, below 0xFF8000; with `rom_en`=0 the window ends at 0xFFFFFF. A non-cacheable fetch does one single-word memory read, returns `fetch_hit`=0 and allocates nothing.
- R6: With `cache_en`=0 every fetch does one single-word memory read with `fetch_hit`=0, and the cache contents are left as they were.
- R7: While `freeze`=1, hits are served as in R1. A miss does one single-word memory read, and no tag, valid or LRU state changes.
- R8: A `flush` cycle in the idle state clears all valid bits at that clock edge. A fetch presented during that cycle is not served until the flush is done, and it then sees an empty cache.
- R9: `fetch_ready` is a one-cycle pulse that is low after reset. `mem_addr` stays stable while `mem_req` is high and `mem_ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | Enables caching; low makes every fetch go to memory |
| freeze | input | 1 | Serve hits but allocate nothing and keep LRU state |
| flush | input | 1 | Invalidate all lines |
| rom_en | input | 1 | On-chip ROM mapped; lowers the top of the cacheable window |
| fetch_req | input | 1 | Core fetch request, held until `fetch_ready` |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_ready | output | 1 | One-cycle pulse: `fetch_data` valid |
| fetch_data | output | DATA_W | Returned instruction word |
| fetch_hit | output | 1 | Word came from the cache (valid with `fetch_ready`) |
| mem_req | output | 1 | External word read request |
| mem_addr | output | ADDR_W | Word-aligned external read address |
| mem_ack | input | 1 | External word delivered this cycle |
| mem_rdata | input | DATA_W | External read data |

## Verification
The bench builds the cache with IDX_W=2, which gives four sets. This puts tag conflicts, both-ways-full eviction and LRU order within reach of a few directed fetches and of a random stream over a dozen lines. The other parameters keep their defaults, so the 24-bit window limits at 0x028000, 0xFF8000 and the top of the space are tested at their real values. Memory latency varies at random from zero to two cycles. This exercises critical-word release in the middle of a fill, and it keeps the memory address under a request that has not yet been acknowledged.

// File: rtl/icache2w_pkg.sv
package icache2w_pkg;
    localparam int BOFF_W     = 4;   // byte offset bits within a line
    localparam int WSEL_W     = 2;   // word select bits within a line
    localparam int LINE_WORDS = 4;
    localparam int WAYS       = 2;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_FILL   = 2'd1,
        S_BYPASS = 2'd2
    } state_e;
endpackage

// File: rtl/icache2w_region.sv
module icache2w_region #(
    parameter int                ADDR_W   = 24,
    parameter int                IDX_W    = 9,
    parameter logic [ADDR_W-1:0] CACHE_LO = 24'h028000,
    parameter logic [ADDR_W-1:0] ROM_TOP  = 24'hFF8000
) (
    input  logic [ADDR_W-1:0]                                  addr,
    input  logic                                               rom_en,
    output logic                                               cacheable,
    output logic [IDX_W-1:0]                                   idx,
    output logic [ADDR_W-icache2w_pkg::BOFF_W-IDX_W-1:0]       tag,
    output logic [icache2w_pkg::WSEL_W-1:0]                    wsel
);
    import icache2w_pkg::*;

    // R5: external window, upper end moves with the ROM mapping
    always_comb begin
        cacheable = (addr >= CACHE_LO) && (!rom_en || (addr < ROM_TOP));
        idx       = addr[BOFF_W +: IDX_W];
        tag       = addr[ADDR_W-1 : BOFF_W+IDX_W];
        wsel      = addr[BOFF_W-1 : BOFF_W-WSEL_W];
    end
endmodule

// File: rtl/icache2w_tags.sv
module icache2w_tags #(
    parameter int IDX_W = 9,
    parameter int TAG_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             lk_way,
    output logic             lk_victim,
    input  logic             flush_all,
    input  logic             alloc_we,
    input  logic             alloc_way,
    input  logic             done_we,
    input  logic [IDX_W-1:0] done_idx,
    input  logic             done_way,
    input  logic             touch_we
);
    import icache2w_pkg::*;
    localparam int SETS = 2**IDX_W;

    logic [SETS-1:0][WAYS-1:0] valid_d, valid_q;
    logic [SETS-1:0]           lru_d, lru_q;     // index of the LRU way
    logic [TAG_W-1:0]          tag_q [SETS][WAYS];
    logic [WAYS-1:0]           match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
    end

    always_comb begin
        lk_hit    = |match;
        lk_way    = match[1];
        // R4: empty way first, then the LRU way
        if (!valid_q[lk_idx][0])      lk_victim = 1'b0;
        else if (!valid_q[lk_idx][1]) lk_victim = 1'b1;
        else                          lk_victim = lru_q[lk_idx];
    end

    always_comb begin
        valid_d = valid_q;
        lru_d   = lru_q;
        if (flush_all) valid_d = '0;
        if (alloc_we)  valid_d[lk_idx][alloc_way] = 1'b0;
        if (done_we) begin
            valid_d[done_idx][done_way] = 1'b1;
            lru_d[done_idx]             = ~done_way;
        end
        if (touch_we) lru_d[lk_idx] = ~lk_way;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            lru_q   <= '0;
        end else begin
            valid_q <= valid_d;
            lru_q   <= lru_d;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_we) tag_q[lk_idx][alloc_way] <= lk_tag;
    end

    AST_ONE_WAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match) <= 1);                                            // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_q == '0));                                     // R8
endmodule

// File: rtl/icache2w_lines.sv
module icache2w_lines #(
    parameter int IDX_W  = 9,
    parameter int DATA_W = 32
) (
    input  logic                                           clk,
    input  logic                                           we,
    input  logic [IDX_W+icache2w_pkg::WSEL_W:0]            widx,
    input  logic [DATA_W-1:0]                              wdata,
    input  logic [IDX_W+icache2w_pkg::WSEL_W:0]            ridx,
    output logic [DATA_W-1:0]                              rdata
);
    import icache2w_pkg::*;
    localparam int DEPTH = 2**(IDX_W + 1 + WSEL_W);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[widx] <= wdata;
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/icache2w.sv
module icache2w #(
    parameter int                ADDR_W   = 24,
    parameter int                IDX_W    = 9,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] CACHE_LO = 24'h028000,
    parameter logic [ADDR_W-1:0] ROM_TOP  = 24'hFF8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              freeze,
    input  logic              flush,
    input  logic              rom_en,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic [DATA_W-1:0] fetch_data,
    output logic              fetch_hit,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    import icache2w_pkg::*;
    localparam int TAG_W = ADDR_W - BOFF_W - IDX_W;
    localparam int WA_W  = ADDR_W - 2;

    typedef struct packed {
        state_e            state;
        logic [WA_W-1:0]   waddr;   // word address of the fetch
        logic [IDX_W-1:0]  set;
        logic              way;
        logic [WSEL_W-1:0] cnt;
        logic [WSEL_W-1:0] want;
        logic              rdy;
        logic              hit;
        logic [DATA_W-1:0] data;
        logic              pend;    // flush waiting for idle
    } regs_t;

    regs_t st_d, st_q;

    logic              lk_cacheable, lk_hit, lk_way, lk_victim;
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic [WSEL_W-1:0] lk_wsel;
    logic              flush_all, alloc_we, done_we, touch_we, dwe;
    logic [DATA_W-1:0] rd_word;

    icache2w_region #(.ADDR_W(ADDR_W), .IDX_W(IDX_W),
                      .CACHE_LO(CACHE_LO), .ROM_TOP(ROM_TOP)) u_region (
        .addr(fetch_addr), .rom_en(rom_en), .cacheable(lk_cacheable),
        .idx(lk_idx), .tag(lk_tag), .wsel(lk_wsel)
    );

    icache2w_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx), .lk_tag(lk_tag),
        .lk_hit(lk_hit), .lk_way(lk_way), .lk_victim(lk_victim),
        .flush_all(flush_all), .alloc_we(alloc_we), .alloc_way(lk_victim),
        .done_we(done_we), .done_idx(st_q.set), .done_way(st_q.way),
        .touch_we(touch_we)
    );

    icache2w_lines #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_lines (
        .clk(clk), .we(dwe), .widx({st_q.set, st_q.way, st_q.cnt}),
        .wdata(mem_rdata), .ridx({lk_idx, lk_way, lk_wsel}), .rdata(rd_word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rdy  = 1'b0;
        flush_all = 1'b0;
        alloc_we  = 1'b0;
        done_we   = 1'b0;
        touch_we  = 1'b0;
        dwe       = 1'b0;
        if (flush) st_d.pend = 1'b1;
        case (st_q.state)
            S_IDLE: begin
                if (flush || st_q.pend) begin            // R8: stall fetches
                    flush_all = 1'b1;
                    st_d.pend = 1'b0;
                end else if (fetch_req && !st_q.rdy) begin
                    st_d.waddr = fetch_addr[ADDR_W-1:2];
                    st_d.set   = lk_idx;
                    st_d.want  = lk_wsel;
                    st_d.cnt   = '0;
                    if (!(cache_en && lk_cacheable)) begin
                        st_d.state = S_BYPASS;           // R5 R6
                    end else if (lk_hit) begin
                        st_d.rdy  = 1'b1;                // R1
                        st_d.hit  = 1'b1;
                        st_d.data = rd_word;
                        touch_we  = !freeze;             // R7
                    end else if (freeze) begin
                        st_d.state = S_BYPASS;           // R7
                    end else begin
                        st_d.state = S_FILL;             // R2 R4
                        st_d.way   = lk_victim;
                        alloc_we   = 1'b1;
                    end
                end
            end
            S_FILL: begin
                if (mem_ack) begin
                    dwe = 1'b1;
                    if (st_q.cnt == st_q.want) begin
                        st_d.rdy  = 1'b1;
                        st_d.hit  = 1'b0;
                        st_d.data = mem_rdata;
                    end
                    if (st_q.cnt == WSEL_W'(LINE_WORDS-1)) begin
                        done_we    = 1'b1;
                        st_d.state = S_IDLE;
                    end
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            S_BYPASS: begin
                if (mem_ack) begin
                    st_d.rdy   = 1'b1;
                    st_d.hit   = 1'b0;
                    st_d.data  = mem_rdata;
                    st_d.state = S_IDLE;
                end
            end
            default: st_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        fetch_ready = st_q.rdy;
        fetch_data  = st_q.data;
        fetch_hit   = st_q.hit;
        mem_req     = (st_q.state == S_FILL) || (st_q.state == S_BYPASS);
        case (st_q.state)
            S_FILL:   mem_addr = {st_q.waddr[WA_W-1:WSEL_W], st_q.cnt, 2'b00};
            S_BYPASS: mem_addr = {st_q.waddr, 2'b00};
            default:  mem_addr = '0;
        endcase
    end

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ready |=> !fetch_ready);                                      // R9
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));          // R9
    AST_FLUSH_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.state == S_IDLE) && (flush || st_q.pend)) |=> (!fetch_ready && !mem_req)); // R8
    AST_FREEZE_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> !(alloc_we || touch_we));                                // R7
    AST_UNCACHED_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.state == S_IDLE) && fetch_req && !st_q.rdy && !flush && !st_q.pend
         && !lk_cacheable) |=> (st_q.state == S_BYPASS));                   // R5
endmodule

// File: tb/icache2w_tb.sv
module icache2w_tb;
    localparam int TB_IDX  = 2;
    localparam int TB_SETS = 4;
    localparam int TB_TAGW = 24 - 4 - TB_IDX;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cache_en = 1'b1, freeze = 1'b0, flush = 1'b0, rom_en = 1'b1;
    logic        fetch_req = 1'b0;
    logic [23:0] fetch_addr = '0;
    logic        fetch_ready, fetch_hit, mem_req, mem_ack = 1'b0;
    logic [31:0] fetch_data, mem_rdata = '0;
    logic [23:0] mem_addr;

    int errors = 0, checks = 0, accesses = 0, mdly = 0;
    logic              mval [TB_SETS][2];
    logic [TB_TAGW-1:0] mtag [TB_SETS][2];
    logic              mlru [TB_SETS];
    logic [23:0]       seen_addr [4];

    always #10 clk = ~clk;

    icache2w #(.IDX_W(TB_IDX)) u_dut (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .freeze(freeze),
        .flush(flush), .rom_en(rom_en), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
        .fetch_data(fetch_data), .fetch_hit(fetch_hit), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] memf(input logic [23:0] a);
        return ({8'h00, a[23:2], 2'b00} * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    function automatic logic in_window(input logic [23:0] a, input logic rom);
        return (a >= 24'h028000) && (!rom || a < 24'hFF8000);
    endfunction

    task automatic chk(input logic ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // memory model: random 0..2 cycle latency, driven away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (mdly == 0) begin
                    mem_ack   = 1'b1;
                    mem_rdata = memf(mem_addr);
                    if (accesses < 4) seen_addr[accesses] = mem_addr;
                    accesses++;
                    mdly = $urandom % 3;
                end else mdly--;
            end
        end
    end

    task automatic model_flush();
        for (int s = 0; s < TB_SETS; s++) begin
            mval[s][0] = 1'b0;
            mval[s][1] = 1'b0;
        end
    endtask

    task automatic do_fetch(input logic [23:0] a, input string rq, input logic with_flush);
        logic [1:0] s;
        logic [TB_TAGW-1:0] t;
        logic eh, got_hit;
        int ea, hw, v, to;
        logic [31:0] got;
        if (with_flush) model_flush();
        s  = a[5:4];
        t  = a[23:6];
        eh = 1'b0;
        ea = 1;
        if (cache_en && in_window(a, rom_en)) begin
            hw = -1;
            for (int w = 0; w < 2; w++)
                if (mval[s][w] && mtag[s][w] == t) hw = w;
            if (hw >= 0) begin
                eh = 1'b1; ea = 0;
                if (!freeze) mlru[s] = (hw == 0);
            end else if (!freeze) begin
                ea = 4;
                v  = !mval[s][0] ? 0 : (!mval[s][1] ? 1 : int'(mlru[s]));
                mval[s][v] = 1'b1;
                mtag[s][v] = t;
                mlru[s]    = (v == 0);
            end
        end
        @(negedge clk);
        accesses   = 0;
        fetch_req  = 1'b1;
        fetch_addr = a;
        if (with_flush) flush = 1'b1;
        to = 0;
        do begin
            @(negedge clk);
            flush = 1'b0;
            to++;
        end while (!fetch_ready && to < 200);
        got = fetch_data;
        got_hit = fetch_hit;
        fetch_req = 1'b0;
        chk(to < 200, rq, "ready timeout", 32'(to), 32'd200);
        to = 0;
        while (mem_req && to < 200) begin @(negedge clk); to++; end
        chk(got == memf(a), rq, $sformatf("data @%06h", a), got, memf(a));
        chk(got_hit == eh, rq, $sformatf("hit @%06h", a), 32'(got_hit), 32'(eh));
        chk(accesses == ea, rq, $sformatf("mem reads @%06h", a), 32'(accesses), 32'(ea));
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        model_flush();
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [23:0] a0, b0, c0, d0, ra;
        void'($urandom(32'd1234));
        for (int s = 0; s < TB_SETS; s++) begin
            mval[s][0] = 1'b0; mval[s][1] = 1'b0; mlru[s] = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk(fetch_ready == 1'b0, "R9", "ready after reset", 32'(fetch_ready), 0);
        chk(mem_req == 1'b0, "R9", "mem_req after reset", 32'(mem_req), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        a0 = 24'h030000; b0 = 24'h030040; c0 = 24'h030080; d0 = 24'h0300C0;
        do_fetch(a0 + 24'h8, "R2", 1'b0);         // miss, word 2 released mid-fill
        for (int i = 0; i < 4; i++)
            chk(seen_addr[i] == a0 + 24'(4*i), "R2", "fill order", 32'(seen_addr[i]), 32'(a0 + 24'(4*i)));
        do_fetch(a0, "R1", 1'b0);
        do_fetch(a0 + 24'hC, "R1", 1'b0);
        do_fetch(b0 + 24'h4, "R3", 1'b0);         // same set, second way
        do_fetch(a0 + 24'h4, "R3", 1'b0);
        do_fetch(b0, "R3", 1'b0);                 // way 0 (a0) now LRU
        do_fetch(c0, "R4", 1'b0);                 // evicts a0
        do_fetch(b0 + 24'h8, "R4", 1'b0);
        do_fetch(a0, "R4", 1'b0);                 // misses again, evicts c0

        do_fetch(24'h027FF0, "R5", 1'b0);
        do_fetch(24'h027FF4, "R5", 1'b0);
        do_fetch(24'h028000, "R5", 1'b0);
        do_fetch(24'h028004, "R5", 1'b0);
        do_fetch(24'hFF8000, "R5", 1'b0);
        do_fetch(24'hFF8000, "R5", 1'b0);
        do_fetch(24'hFF7FF0, "R5", 1'b0);
        rom_en = 1'b0;
        do_fetch(24'hFFFFFC, "R5", 1'b0);
        do_fetch(24'hFFFFF0, "R5", 1'b0);
        rom_en = 1'b1;

        cache_en = 1'b0;
        do_fetch(a0, "R6", 1'b0);
        do_fetch(d0, "R6", 1'b0);
        cache_en = 1'b1;
        do_fetch(a0 + 24'h4, "R6", 1'b0);         // still resident
        do_fetch(d0, "R6", 1'b0);                 // was not allocated

        freeze = 1'b1;
        do_fetch(d0 + 24'h4, "R7", 1'b0);
        do_fetch(c0, "R7", 1'b0);
        do_fetch(c0, "R7", 1'b0);
        freeze = 1'b0;
        do_fetch(c0, "R7", 1'b0);

        do_flush();
        do_fetch(d0, "R8", 1'b0);
        do_fetch(d0, "R8", 1'b0);
        do_fetch(d0 + 24'h8, "R8", 1'b1);         // fetch during flush cycle

        for (int n = 0; n < 400; n++) begin
            freeze   = (($urandom % 8) == 0);
            cache_en = (($urandom % 16) != 0);
            if (($urandom % 30) == 0) do_flush();
            if (($urandom % 20) == 0) ra = 24'h020000 + 24'(($urandom % 8) * 4);
            else ra = 24'h040000 + 24'(($urandom % 12) * 16) + 24'(($urandom % 4) * 4);
            do_fetch(ra, "R1/R2/R4", 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule